// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Front-End

This block sits on the bus side of a two-wire serial EEPROM and handles write transactions only. It watches the clock and data lines, which are already synchronised to the system clock, and finds Start and Stop conditions. It shifts in the device-select byte and compares it with a fixed device-type code and three strap inputs. On a match it acknowledges by pulling the data line low. It then takes in a two-byte word address and any number of data bytes. Each of these is handed downstream as a one-cycle strobe.

A Stop that ends a write holding at least one data byte tells the write engine to begin its internal program cycle. While the engine reports busy, the block acknowledges nothing. A master can therefore poll with a Start and a write select until it sees an acknowledge again. The data line is driven only as an open-drain pull-low enable. Read transfers and clock stretching are not handled.

Top module: `ee_wr_frontend`

## Requirements
- R1: After a synchronous reset `sda_pull`, `addr_stb`, `data_stb` and `prog_start` are all low.
- R2: A Start is SDA falling while SCL is high and a Stop is SDA rising while SCL is high. Either one discards a partly received byte, so the next byte counts from its first bit.
- R3: A select byte is acknowledged when bits 7..4 equal 4'b1010, bits 3..1 equal `dev_sel[2:0]` (bit 1 against `dev_sel[0]`) and bit 0 (direction) is 0. The acknowledge keeps SDA low while SCL is high in the ninth clock.
- R4: A select byte with a wrong code, wrong strap bits or direction bit 1 is not acknowledged. Every byte after it up to the next Start is also ignored: no acknowledge and no strobe.
- R5: After an accepted select byte, two word-address bytes are each acknowledged. After the second one, `addr_stb` pulses once and `word_addr` holds {first byte, second byte}.
- R6: Every data byte after the word address is acknowledged. For each one, `data_stb` pulses once with the byte on `data_byte`, in the order received.
- R7: A Stop pulses `prog_start` for one cycle only if at least one data byte arrived since the last Start. A Stop after only address bytes gives no pulse.
- R8: While `busy` is high when a byte completes, that byte is not acknowledged and the block ignores the bus until the next Start. Once `busy` is low, a matching select byte is acknowledged again.
- R9: `sda_pull` rises only after the falling SCL edge that ends the eighth bit, and it is released on the falling SCL edge that ends the ninth clock.
- R10: Bytes are received most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Synchronised bus clock level |
| sda | input | 1 | Synchronised bus data level (wired-AND of all drivers) |
| dev_sel | input | 3 | Strapped device-select bits |
| busy | input | 1 | Write engine is running a program cycle |
| sda_pull | output | 1 | Pull-low enable for the open-drain data pad |
| addr_stb | output | 1 | One-cycle pulse: word address received |
| word_addr | output | 16 | Received word address |
| data_stb | output | 1 | One-cycle pulse: data byte received |
| data_byte | output | 8 | Received data byte |
| prog_start | output | 1 | One-cycle pulse: start the program cycle |

## Verification
Random select bytes with random strap settings and busy levels are compared against a computed match. This separates errors in the code compare, the strap compare and the direction bit. Full writes with random word addresses and one to six data bytes check the ordering of the address halves, the data sequence and that exactly one program pulse follows. Directed cases cover a Stop after only the address, a byte cut off by a Start, a poll that is refused while busy and accepted afterwards, and busy rising in the middle of a transfer. These show whether abort, polling and the program trigger are kept apart.

// File: rtl/ee_wr_pkg.sv
// Shared types for the two-wire EEPROM write front-end.
// Assumes nothing beyond IEEE 1800-2017.
package ee_wr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,    // not addressed, wait for Start
        PH_DEV,     // receiving device-select byte
        PH_WAH,     // receiving high word-address byte
        PH_WAL,     // receiving low word-address byte
        PH_DATA     // receiving data bytes
    } phase_t;
endpackage

// File: rtl/ee_bus_cond.sv
// Bus condition detector: finds SCL edges and Start/Stop conditions.
// Assumes scl/sda are already synchronised to clk. Idle bus is high.
module ee_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q;
    logic sda_q;

    // Remember last line levels; reset to idle-high so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Decode edges and conditions from previous and current levels.
    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/ee_byte_rx.sv
// Byte receiver: shifts in W bits MSB first on rising SCL, then skips
// the acknowledge clock. Assumes abort (Start/Stop) clears the count.
module ee_byte_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_rise,
    input  logic         abort,
    input  logic         sda,
    output logic         byte_ok,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] ACKC = CW'(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;

    // Bit counter and shift register; the count W marks the ack clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else if (scl_rise) begin
            if (cnt == ACKC) begin
                cnt <= '0;
            end else begin
                shreg <= {shreg[W-2:0], sda};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // Byte completes on the rising edge of its last bit.
    always_comb begin
        byte_ok = scl_rise && !abort && (cnt == LAST);
        rx_byte = {shreg[W-2:0], sda};
    end

    // Counter never passes the acknowledge slot.
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ACKC);
    // Completion of a byte is always followed by the ack-clock slot.
    assert_ack_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ok |=> (cnt == ACKC));
endmodule

// File: rtl/ee_wr_ctrl.sv
// Write transaction controller: decides acknowledges, drives the
// pull-low enable, and issues address/data/program strobes.
// Assumes byte_ok and scl_fall never coincide (rise vs fall of SCL).
module ee_wr_ctrl
    import ee_wr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter int         SEL_W    = 3,
    parameter int         BW       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_fall,
    input  logic            start_c,
    input  logic            stop_c,
    input  logic            byte_ok,
    input  logic [BW-1:0]   rx_byte,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic            busy,
    output logic            sda_pull,
    output logic            addr_stb,
    output logic [2*BW-1:0] word_addr,
    output logic            data_stb,
    output logic [BW-1:0]   data_byte,
    output logic            prog_start
);
    localparam int WA_W = 2 * BW;

    phase_t        phase;
    logic          ack_pend;
    logic          seen_data;
    logic [BW-1:0] wa_hi;
    logic          sel_match;

    // Select byte compare: code, strap bits, write direction.
    always_comb begin
        sel_match = (rx_byte[BW-1:BW-4] == DEV_CODE)
                 && (rx_byte[SEL_W:1] == dev_sel)
                 && !rx_byte[0];
    end

    // Transaction sequencing, acknowledge timing and downstream strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            ack_pend   <= 1'b0;
            seen_data  <= 1'b0;
            sda_pull   <= 1'b0;
            wa_hi      <= '0;
            word_addr  <= '0;
            data_byte  <= '0;
            addr_stb   <= 1'b0;
            data_stb   <= 1'b0;
            prog_start <= 1'b0;
        end else begin
            addr_stb   <= 1'b0;
            data_stb   <= 1'b0;
            prog_start <= 1'b0;
            if (start_c) begin
                phase     <= PH_DEV;
                ack_pend  <= 1'b0;
                sda_pull  <= 1'b0;
                seen_data <= 1'b0;
            end else if (stop_c) begin
                phase      <= PH_IDLE;
                ack_pend   <= 1'b0;
                sda_pull   <= 1'b0;
                prog_start <= seen_data;
                seen_data  <= 1'b0;
            end else begin
                if (scl_fall) begin
                    if (sda_pull) begin
                        sda_pull <= 1'b0;
                    end else if (ack_pend) begin
                        sda_pull <= 1'b1;
                        ack_pend <= 1'b0;
                    end
                end
                if (byte_ok && phase != PH_IDLE) begin
                    if (busy) begin
                        phase <= PH_IDLE;
                    end else begin
                        case (phase)
                            PH_DEV: begin
                                if (sel_match) begin
                                    ack_pend <= 1'b1;
                                    phase    <= PH_WAH;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_WAH: begin
                                wa_hi    <= rx_byte;
                                ack_pend <= 1'b1;
                                phase    <= PH_WAL;
                            end
                            PH_WAL: begin
                                word_addr <= WA_W'({wa_hi, rx_byte});
                                addr_stb  <= 1'b1;
                                ack_pend  <= 1'b1;
                                phase     <= PH_DATA;
                            end
                            PH_DATA: begin
                                data_byte <= rx_byte;
                                data_stb  <= 1'b1;
                                seen_data <= 1'b1;
                                ack_pend  <= 1'b1;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    // Busy at byte completion never yields an acknowledge.
    assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && busy) |=> !ack_pend);
    // A wrong device code drops the block to idle.
    assert_code_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && !start_c && !stop_c && phase == PH_DEV
         && rx_byte[BW-1:BW-4] != DEV_CODE) |=> (phase == PH_IDLE));
    // Pull is released on the falling edge that ends the ack clock.
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull && scl_fall && !start_c && !stop_c) |=> !sda_pull);
    // Program pulse only follows a Stop.
    assert_prog_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(stop_c));
    // Data strobes only come in the data phase.
    assert_data_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> (phase == PH_DATA));
endmodule

// File: rtl/ee_wr_frontend.sv
// Top of the two-wire EEPROM slave write front-end.
// Assumes synchronised scl/sda inputs and an external open-drain pad
// that pulls the data line low while sda_pull is high.
module ee_wr_frontend #(
    parameter logic [3:0] DEV_CODE = 4'b1010,
    parameter int         SEL_W    = 3,
    parameter int         BW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic              busy,
    output logic              sda_pull,
    output logic              addr_stb,
    output logic [2*BW-1:0]   word_addr,
    output logic              data_stb,
    output logic [BW-1:0]     data_byte,
    output logic              prog_start
);
    logic          scl_rise;
    logic          scl_fall;
    logic          start_c;
    logic          stop_c;
    logic          byte_ok;
    logic [BW-1:0] rx_byte;
    logic          abort;

    assign abort = start_c | stop_c;

    ee_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl),
        .sda      (sda),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    ee_byte_rx #(.W(BW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .abort    (abort),
        .sda      (sda),
        .byte_ok  (byte_ok),
        .rx_byte  (rx_byte)
    );

    ee_wr_ctrl #(.DEV_CODE(DEV_CODE), .SEL_W(SEL_W), .BW(BW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_fall   (scl_fall),
        .start_c    (start_c),
        .stop_c     (stop_c),
        .byte_ok    (byte_ok),
        .rx_byte    (rx_byte),
        .dev_sel    (dev_sel),
        .busy       (busy),
        .sda_pull   (sda_pull),
        .addr_stb   (addr_stb),
        .word_addr  (word_addr),
        .data_stb   (data_stb),
        .data_byte  (data_byte),
        .prog_start (prog_start)
    );

    // The pull changes only while SCL is low (never forms a condition).
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(scl));
endmodule

// File: tb/tb_ee_wr_frontend.sv
module tb_ee_wr_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  dev_sel = 3'b000;
    logic        busy = 1'b0;
    logic        sda_pull;
    logic        addr_stb;
    logic [15:0] word_addr;
    logic        data_stb;
    logic [7:0]  data_byte;
    logic        prog_start;
    wire         sda_line = m_sda & ~sda_pull;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;

    int unsigned n_addr = 0;
    int unsigned n_data = 0;
    int unsigned n_prog = 0;
    logic [15:0] last_addr = '0;
    logic [7:0]  got [$];

    always #5 clk = ~clk;

    ee_wr_frontend dut (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_line),
        .dev_sel(dev_sel), .busy(busy), .sda_pull(sda_pull),
        .addr_stb(addr_stb), .word_addr(word_addr), .data_stb(data_stb),
        .data_byte(data_byte), .prog_start(prog_start)
    );

    // Record downstream strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_stb) begin n_addr++; last_addr = word_addr; end
            if (data_stb) begin n_data++; got.push_back(data_byte); end
            if (prog_start) n_prog++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_match(input logic [7:0] b, input logic [2:0] s, input logic bz);
        return (b[7:4] == 4'hA) && (b[3:1] == s) && !b[0] && !bz;
    endfunction

    task automatic do_start();
        m_sda = 1'b1; tick(4);
        scl = 1'b1; tick(4);
        m_sda = 1'b0; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(4);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(4);
    endtask

    // Sends a byte MSB first, returns the acknowledge, checks pull timing.
    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit pre;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        pre = sda_pull;
        m_sda = 1'b1; tick(4);
        scl = 1'b1; tick(2);
        acked = !sda_line;
        tick(2);
        scl = 1'b0; tick(4);
        chk(pre == acked, "R9 pull set after 8th fall", pre, acked);
        chk(sda_pull == 1'b0, "R9 pull released on 9th fall", sda_pull, 0);
    endtask

    // Full write; checks acks, address, data order and program pulse.
    task automatic full_write(input logic [15:0] wa, input int nd);
        bit a;
        logic [7:0] exp_d [$];
        int unsigned p0;
        exp_d = {};
        got = {};
        p0 = n_prog;
        do_start();
        send_byte({4'hA, dev_sel, 1'b0}, a);
        chk(a, "R3 select ack", a, 1);
        send_byte(wa[15:8], a);
        chk(a, "R5 addr hi ack", a, 1);
        send_byte(wa[7:0], a);
        chk(a, "R5 addr lo ack", a, 1);
        tick(1);
        chk(last_addr == wa, "R5 word_addr", last_addr, wa);
        for (int k = 0; k < nd; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            exp_d.push_back(d);
            send_byte(d, a);
            chk(a, "R6 data ack", a, 1);
        end
        do_stop();
        tick(2);
        chk(got.size() == nd, "R6 data count", got.size(), nd);
        for (int k = 0; k < nd && k < got.size(); k++)
            chk(got[k] == exp_d[k], "R6 data order R10", got[k], exp_d[k]);
        chk((n_prog - p0) == ((nd > 0) ? 1 : 0), "R7 program pulse", n_prog - p0, (nd > 0) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit a;
        int unsigned pd, pa, pp;
        void'($urandom(32'd2024));
        tick(5);
        chk(!sda_pull && !addr_stb && !data_stb && !prog_start, "R1 reset outputs",
            {sda_pull, addr_stb, data_stb, prog_start}, 0);
        rst_n = 1'b1;
        tick(5);

        // Directed full write and a few random full writes.
        dev_sel = 3'b101;
        full_write(16'h12C3, 1);
        for (int t = 0; t < 6; t++) begin
            dev_sel = 3'($urandom);
            full_write(16'($urandom), 1 + int'($urandom % 6));
        end

        // Stop after address only: no program pulse.
        full_write(16'h0F0F, 0);

        // Random select bytes with random busy.
        for (int t = 0; t < 24; t++) begin
            logic [7:0] b;
            bit e;
            dev_sel = 3'($urandom);
            busy = ($urandom % 4) == 0;
            b = (($urandom % 2) == 0) ? {4'hA, 3'($urandom), 1'($urandom)} : 8'($urandom);
            e = exp_match(b, dev_sel, busy);
            do_start();
            send_byte(b, a);
            chk(a == e, "R3 R4 R8 select decision", a, e);
            do_stop();
        end
        busy = 1'b0;

        // Wrong code: later bytes ignored, no strobes, no program pulse.
        dev_sel = 3'b010;
        pa = n_addr; pd = n_data; pp = n_prog;
        do_start();
        send_byte(8'hB4, a);
        chk(!a, "R4 wrong code nack", a, 0);
        send_byte(8'h00, a); chk(!a, "R4 ignored byte", a, 0);
        send_byte(8'h11, a); chk(!a, "R4 ignored byte", a, 0);
        send_byte(8'h22, a); chk(!a, "R4 ignored byte", a, 0);
        do_stop(); tick(2);
        chk(n_addr == pa && n_data == pd && n_prog == pp, "R4 no strobes",
            n_addr + n_data + n_prog, pa + pd + pp);

        // Read direction and wrong strap rejected.
        do_start(); send_byte(8'hA5, a); chk(!a, "R4 read direction nack", a, 0); do_stop();
        do_start(); send_byte(8'hA6, a); chk(!a, "R4 strap mismatch nack", a, 0); do_stop();

        // Partial byte cut by Start, then a good select.
        do_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_start();
        send_byte(8'hA4, a);
        chk(a, "R2 abort then select ack", a, 1);
        do_stop();

        // Partial byte cut by Stop, then a full write.
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        scl = 1'b0; tick(4);
        do_stop();
        full_write(16'hBEEF, 2);

        // Ack polling: refused while busy, accepted after.
        busy = 1'b1;
        do_start(); send_byte({4'hA, dev_sel, 1'b0}, a);
        chk(!a, "R8 poll while busy", a, 0); do_stop();
        busy = 1'b0;
        do_start(); send_byte({4'hA, dev_sel, 1'b0}, a);
        chk(a, "R8 poll after busy", a, 1); do_stop();

        // Busy rises before the first data byte.
        pd = n_data; pp = n_prog;
        do_start();
        send_byte({4'hA, dev_sel, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        busy = 1'b1;
        send_byte(8'h77, a);
        chk(!a, "R8 data nack while busy", a, 0);
        busy = 1'b0;
        send_byte(8'h78, a);
        chk(!a, "R8 ignored until Start", a, 0);
        do_stop(); tick(2);
        chk(n_data == pd && n_prog == pp, "R8 no data or program", n_data + n_prog, pd + pp);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule